// File: doc/BRIEF.md
# Flash Transfer Chunking Engine

This block sits between a caller that wants to move an arbitrary run of bytes to or from serial flash and a flash command controller that can only carry a short, fixed menu of data lengths per command. The caller gives one request: a start address, a total byte count, a direction and a flag saying whether the command has a data phase at all. The engine cuts that request into a sequence of controller commands. No command crosses a 256-byte flash page. Each command length is one the controller accepts: 0 to 8 bytes, or a multiple of 8 up to 64.

For every piece the engine works in a fixed order. For a write, it first copies the bytes from the caller's buffer into the controller's data buffer. It then raises a one-cycle go strobe and waits for the controller's in-progress flag to drop. For a read, it copies the returned bytes into the caller's buffer only after that completion. It then advances the flash address and the caller-buffer offset. The request ends with a one-cycle done pulse, or with a one-cycle error pulse that carries a cause bit telling a blocked access apart from a timeout.

Top module: `flash_chunker`

## Requirements
- R1: No command crosses a 256-byte address boundary. When the remaining bytes would cross one, the command ends exactly at that boundary.
- R2: After boundary clipping, a piece of 64 bytes or more is issued as exactly 64 bytes.
- R3: After boundary clipping, a piece of 8 to 63 bytes is rounded down to a multiple of 8. A piece below 8 bytes is issued unchanged.
- R4: After each command, the flash address and the caller-buffer offset both advance by the command length, and the remaining count drops by the same amount. Commands continue until the remaining count is zero. A request with a data phase and a count of zero issues one command of length 0. Success ends with `done` high for one cycle.
- R5: With the data-phase flag clear, the count is taken as zero. Exactly one command is issued, with `cmd_data` low and `cmd_len` 0, and neither buffer is written.
- R6: Before its first command, the engine waits for `ctl_busy` to be low. `cmd_go` is never raised while `ctl_busy` is high.
- R7: If `ctl_blocked` is high when `ctl_busy` falls after a command, the request ends with `err` high for one cycle and `err_timeout` low, and no further command is issued.
- R8: If `ctl_busy` stays high for more than `TIMEOUT_CYC` cycles, the request ends with `err` high and `err_timeout` high. This applies to the wait before the first command and to the wait for each completion.
- R9: For a write, controller buffer slots 0 to len-1 hold the caller bytes at offsets ptr to ptr+len-1 before `cmd_go` rises. For a read, the caller bytes at those offsets are taken from slots 0 to len-1 after completion.
- R10: `start` is acted on only while `busy` is low, and a `start` raised during a request has no effect on it. `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| start_addr | input | ADDR_W | First flash byte address |
| start_count | input | CNT_W | Total bytes to move |
| start_write | input | 1 | 1 = write to flash, 0 = read from flash |
| start_data | input | 1 | Command has a data phase |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request succeeds |
| err | output | 1 | One-cycle pulse when a request fails |
| err_timeout | output | 1 | Failure cause: 1 = timeout, 0 = blocked access |
| cmd_go | output | 1 | One-cycle command start to the controller |
| cmd_addr | output | ADDR_W | Flash address of the command |
| cmd_len | output | LEN_W | Data bytes in the command (0..64) |
| cmd_write | output | 1 | Data flows out to flash |
| cmd_data | output | 1 | Command has a data phase |
| ctl_busy | input | 1 | Controller cycle in progress |
| ctl_blocked | input | 1 | Controller reports the last cycle was blocked |
| ctl_buf_we | output | 1 | Write strobe into the controller data buffer |
| ctl_buf_idx | output | IDX_W | Controller data buffer slot |
| ctl_buf_wdata | output | 8 | Byte into the controller data buffer |
| ctl_buf_rdata | input | 8 | Byte from the controller data buffer slot (combinational) |
| usr_addr | output | CNT_W | Caller buffer byte offset |
| usr_we | output | 1 | Write strobe into the caller buffer |
| usr_wdata | output | 8 | Byte into the caller buffer |
| usr_rdata | input | 8 | Byte from the caller buffer offset (combinational) |

## Verification
A wrong length or a wrong address step shows up at the very next `cmd_go`. There the address or length differs from the list the scoreboard derives from the page and quantisation rules, so the error is caught one command after it happens. A copy step running in the wrong order or over the wrong range shows up as stale bytes. For writes this is visible in the controller buffer when `cmd_go` rises. For reads it is visible in the caller buffer once `done` pulses. A timer or completion-check fault shows up as a missing or misattributed `err`, or as a `cmd_go` raised while the controller is still busy.

// File: rtl/flash_chunker_pkg.sv
package flash_chunker_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PREP,
    ST_LOAD,
    ST_ISSUE,
    ST_SETTLE,
    ST_POLL,
    ST_UNLOAD,
    ST_ADV
  } fc_state_e;
endpackage

// File: rtl/fc_chunk_sizer.sv
module fc_chunk_sizer #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int QUANT      = 8,
  parameter int LEN_W      = $clog2(MAX_CHUNK + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  remaining,
  output logic [LEN_W-1:0]  len
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  // Clip to the page end, cap at MAX_CHUNK, quantise mid-range lengths.
  function automatic int unsigned fit_len(int unsigned page_off, int unsigned rem);
    int unsigned room;
    int unsigned c;
    room = PAGE_BYTES - page_off;
    c = (rem < room) ? rem : room;
    if (c >= MAX_CHUNK) c = MAX_CHUNK;
    else if (c >= QUANT) c = c - (c % QUANT);
    return c;
  endfunction

  assign len = LEN_W'(fit_len(32'(addr[PAGE_W-1:0]), 32'(remaining)));
endmodule

// File: rtl/fc_copy_counter.sv
module fc_copy_counter #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  assign at_last = (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || !step) idx <= '0;
    else if (at_last)    idx <= '0;
    else                 idx <= idx + 1'b1;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> idx <= last_idx); // R9
endmodule

// File: rtl/fc_wait_timer.sv
module fc_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R8
endmodule

// File: rtl/flash_chunker.sv
module flash_chunker
  import flash_chunker_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int MAX_CHUNK   = 64,
  parameter int QUANT       = 8,
  parameter int TIMEOUT_CYC = 1000,
  localparam int LEN_W      = $clog2(MAX_CHUNK + 1),
  localparam int IDX_W      = $clog2(MAX_CHUNK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              start_write,
  input  logic              start_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              err_timeout,
  output logic              cmd_go,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_write,
  output logic              cmd_data,
  input  logic              ctl_busy,
  input  logic              ctl_blocked,
  output logic              ctl_buf_we,
  output logic [IDX_W-1:0]  ctl_buf_idx,
  output logic [7:0]        ctl_buf_wdata,
  input  logic [7:0]        ctl_buf_rdata,
  output logic [CNT_W-1:0]  usr_addr,
  output logic              usr_we,
  output logic [7:0]        usr_wdata,
  input  logic [7:0]        usr_rdata
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  fc_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  ptr_q;
  logic [LEN_W-1:0]  cur_len;
  logic              wr_q, de_q;
  logic              done_q, err_q, err_to_q;

  // Named internal events
  logic [LEN_W-1:0]  next_len;
  logic [CNT_W-1:0]  rem_next;
  logic              waiting, expired;
  logic              copying, copy_last;
  logic [IDX_W-1:0]  copy_idx, copy_last_idx;
  logic              ctl_done_ev, blocked_ev;

  fc_chunk_sizer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
    .MAX_CHUNK(MAX_CHUNK), .QUANT(QUANT), .LEN_W(LEN_W)
  ) u_sizer (
    .addr(addr_q), .remaining(rem_q), .len(next_len)
  );

  assign waiting = (state == ST_CHECK) || (state == ST_POLL);

  fc_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .expired(expired)
  );

  assign copying       = (state == ST_LOAD) || (state == ST_UNLOAD);
  assign copy_last_idx = IDX_W'(cur_len - 1'b1);

  fc_copy_counter #(.IDX_W(IDX_W)) u_copy (
    .clk(clk), .rst_n(rst_n), .step(copying), .last_idx(copy_last_idx),
    .idx(copy_idx), .at_last(copy_last)
  );

  assign rem_next    = rem_q - CNT_W'(cur_len);
  assign ctl_done_ev = (state == ST_POLL) && !ctl_busy;
  assign blocked_ev  = ctl_done_ev && ctl_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      ptr_q    <= '0;
      cur_len  <= '0;
      wr_q     <= 1'b0;
      de_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      err_to_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          addr_q   <= start_addr;
          rem_q    <= start_data ? start_count : '0;
          ptr_q    <= '0;
          wr_q     <= start_write;
          de_q     <= start_data;
          err_to_q <= 1'b0;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!ctl_busy) state <= ST_PREP;
          else if (expired) begin
            err_q <= 1'b1; err_to_q <= 1'b1; state <= ST_IDLE;
          end
        end
        ST_PREP: begin
          cur_len <= next_len;
          state   <= (wr_q && next_len != '0) ? ST_LOAD : ST_ISSUE;
        end
        ST_LOAD:   if (copy_last) state <= ST_ISSUE;
        ST_ISSUE:  state <= ST_SETTLE;
        ST_SETTLE: state <= ST_POLL;
        ST_POLL: begin
          if (ctl_done_ev) begin
            if (blocked_ev) begin
              err_q <= 1'b1; err_to_q <= 1'b0; state <= ST_IDLE;
            end else if (!wr_q && cur_len != '0) state <= ST_UNLOAD;
            else state <= ST_ADV;
          end else if (expired) begin
            err_q <= 1'b1; err_to_q <= 1'b1; state <= ST_IDLE;
          end
        end
        ST_UNLOAD: if (copy_last) state <= ST_ADV;
        ST_ADV: begin
          addr_q <= addr_q + ADDR_W'(cur_len);
          ptr_q  <= ptr_q + CNT_W'(cur_len);
          rem_q  <= rem_next;
          if (rem_next == '0) begin
            done_q <= 1'b1; state <= ST_IDLE;
          end else state <= ST_PREP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign done          = done_q;
  assign err           = err_q;
  assign err_timeout   = err_to_q;
  assign cmd_go        = (state == ST_ISSUE);
  assign cmd_addr      = addr_q;
  assign cmd_len       = cur_len;
  assign cmd_write     = wr_q;
  assign cmd_data      = de_q;
  assign ctl_buf_we    = (state == ST_LOAD);
  assign ctl_buf_idx   = copy_idx;
  assign ctl_buf_wdata = usr_rdata;
  assign usr_addr      = ptr_q + CNT_W'(copy_idx);
  assign usr_we        = (state == ST_UNLOAD);
  assign usr_wdata     = ctl_buf_rdata;

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (32'(cmd_addr[PAGE_W-1:0]) + 32'(cmd_len)) <= 32'(PAGE_BYTES)); // R1
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> 32'(cmd_len) <= 32'(MAX_CHUNK)); // R2
  AST_LEN_QUANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && 32'(cmd_len) >= 32'(QUANT)) |-> (32'(cmd_len) % 32'(QUANT)) == 0); // R3
  AST_NODATA_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !cmd_data) |-> cmd_len == '0); // R5
  AST_GO_CTL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !ctl_busy); // R6
  AST_BLOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_ev |=> err && !err_timeout && !cmd_go); // R7
  AST_LOAD_BEFORE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !ctl_buf_we && !usr_we); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
endmodule

// File: tb/flash_chunker_bench.sv
module flash_chunker_bench;
  localparam int AW = 24, CW = 12, LW = 7, IW = 6, TO = 40, LAT = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, start_write, start_data;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] start_count;
  logic busy, done, err, err_timeout, cmd_go, cmd_write, cmd_data;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic ctl_busy, ctl_blocked, ctl_buf_we, usr_we;
  logic [IW-1:0] ctl_buf_idx;
  logic [7:0] ctl_buf_wdata, ctl_buf_rdata, usr_wdata, usr_rdata;
  logic [CW-1:0] usr_addr;

  flash_chunker #(.ADDR_W(AW), .CNT_W(CW), .TIMEOUT_CYC(TO)) u_flash_chunker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .start_write(start_write), .start_data(start_data),
    .busy(busy), .done(done), .err(err), .err_timeout(err_timeout),
    .cmd_go(cmd_go), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_write(cmd_write), .cmd_data(cmd_data),
    .ctl_busy(ctl_busy), .ctl_blocked(ctl_blocked),
    .ctl_buf_we(ctl_buf_we), .ctl_buf_idx(ctl_buf_idx),
    .ctl_buf_wdata(ctl_buf_wdata), .ctl_buf_rdata(ctl_buf_rdata),
    .usr_addr(usr_addr), .usr_we(usr_we), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata)
  );

  int n_chk = 0, n_bad = 0, go_cnt = 0, done_cnt = 0;

  function automatic logic [7:0] src_pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] fl_pat(int a);
    return 8'(((a ^ (a >> 8)) + 'h5A) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Controller and memory models
  logic [7:0] cbuf [64];
  logic [7:0] dst  [256];
  logic mdl_busy_r, force_busy, hang, blk, fill_req;
  int mdl_cnt;
  assign ctl_busy      = mdl_busy_r | force_busy;
  assign ctl_blocked   = blk;
  assign ctl_buf_rdata = cbuf[ctl_buf_idx];
  assign usr_rdata     = src_pat(int'(usr_addr));

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_busy_r <= 1'b0; mdl_cnt <= 0;
    end else if (cmd_go) begin
      mdl_busy_r <= 1'b1; mdl_cnt <= LAT;
      if (!cmd_write) for (int i = 0; i < 64; i++) cbuf[i] <= fl_pat(int'(cmd_addr) + i);
    end else if (mdl_busy_r && !hang) begin
      if (mdl_cnt <= 1) mdl_busy_r <= 1'b0;
      mdl_cnt <= mdl_cnt - 1;
    end
    if (ctl_buf_we) cbuf[ctl_buf_idx] <= ctl_buf_wdata;
    if (fill_req) for (int i = 0; i < 256; i++) dst[i] <= 8'hEE;
    else if (usr_we) dst[usr_addr[7:0]] <= usr_wdata;
  end

  // Scoreboard
  typedef struct { int addr; int len; int ptr; bit wr; bit de; } chunk_t;
  chunk_t exp_q[$];

  task automatic push_chunks(input int a, input int c, input bit wr, input bit de, input int lim);
    int rem, p, ad, n, room, ch;
    rem = de ? c : 0; p = 0; ad = a; n = 0;
    do begin
      room = ((ad | 255) + 1) - ad;
      ch = (rem < room) ? rem : room;
      if (ch > 64) ch = 64;
      else if (ch > 7) ch = ch & ~7;
      exp_q.push_back('{ad, ch, p, wr, de});
      ad += ch; p += ch; rem -= ch; n++;
    end while (rem > 0 && n < lim);
  endtask

  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check(0, "R10", "done longer than one cycle", 1, 0);
      if (done && err) check(0, "R10", "done and err together", 1, 0);
      prev_done = done;
      if (done) done_cnt++;
      if (cmd_go) begin
        go_cnt++;
        check(!ctl_busy, "R6", "go while controller busy", int'(ctl_busy), 0);
        if (exp_q.size() == 0) check(0, "R4", "unexpected command", int'(cmd_addr), -1);
        else begin
          chunk_t e;
          bit bok;
          e = exp_q.pop_front();
          check(int'(cmd_addr) == e.addr, "R4", "command address", int'(cmd_addr), e.addr);
          check(int'(cmd_len) == e.len, "R1 R2 R3", "command length", int'(cmd_len), e.len);
          check(cmd_data == e.de && cmd_write == e.wr, "R5", "command flags",
                int'({cmd_data, cmd_write}), int'({e.de, e.wr}));
          if (e.wr && e.len > 0) begin
            bok = 1'b1;
            for (int i = 0; i < e.len; i++) if (cbuf[i] != src_pat(e.ptr + i)) bok = 1'b0;
            check(bok, "R9", "write buffer loaded before go", e.ptr, e.ptr);
          end
        end
      end
    end
  end

  // Driver: mode 0 success, 1 blocked, 2 completion timeout, 3 pre-wait timeout
  task automatic run_req(input int a, input int c, input bit wr, input bit de,
                         input int mode, input bit poke, input string req);
    int n_exp, g0;
    bit saw_done, saw_err, saw_to;
    saw_done = 0; saw_err = 0; saw_to = 0;
    if (mode != 3) push_chunks(a, c, wr, de, (mode == 0) ? 1000 : 1);
    n_exp = exp_q.size();
    g0 = go_cnt;
    @(negedge clk);
    start_addr = AW'(a); start_count = CW'(c); start_write = wr; start_data = de; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000 && !saw_done && !saw_err; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; start_addr = AW'(8); start_count = CW'(7); start_write = ~wr;
      end else start = 1'b0;
      saw_done = done; saw_err = err; saw_to = err_timeout;
      if (!saw_done && !saw_err) @(negedge clk);
    end
    start = 1'b0;
    if (mode == 0) check(saw_done && !saw_err, req, "request ends with done", int'(saw_done), 1);
    else check(saw_err && (saw_to == (mode >= 2)), req, "error and cause",
               int'({saw_err, saw_to}), int'({1'b1, mode >= 2}));
    check(go_cnt - g0 == n_exp, req, "command count", go_cnt - g0, n_exp);
    check(exp_q.size() == 0, "R4", "chunks left unissued", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !err, "R10", "status pulses drop", int'({done, err}), 0);
  endtask

  task automatic check_read(input int a, input int c, input string req);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < c; i++) if (dst[i] != fl_pat(a + i)) ok = 1'b0;
    check(ok, req, "read data unloaded into caller buffer", c, c);
  endtask

  task automatic clear_dst();
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  initial begin
    bit untouched;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; start_count = '0;
    start_write = 1'b0; start_data = 1'b0;
    force_busy = 1'b0; hang = 1'b0; blk = 1'b0; fill_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !cmd_go, "R10", "reset idle state",
          int'({busy, done, err, cmd_go}), 0);

    // R3: 20 bytes -> 16 + 4, write
    run_req('h000100, 20, 1'b1, 1'b1, 0, 1'b0, "R3");
    // R1 R2 R3: read 200 at 0xF0 -> 16, 64, 64, 56
    clear_dst();
    run_req('h0000F0, 200, 1'b0, 1'b1, 0, 1'b0, "R1");
    check_read('h0000F0, 200, "R9");
    // R1: write 75 at 0x1FFC -> 4, 64, 7
    run_req('h001FFC, 75, 1'b1, 1'b1, 0, 1'b0, "R1");
    // R3: read 13 at 0x2005 -> 8, 5
    clear_dst();
    run_req('h002005, 13, 1'b0, 1'b1, 0, 1'b0, "R3");
    check_read('h002005, 13, "R9");
    // R2: read 128 page aligned -> 64, 64
    clear_dst();
    run_req('h030000, 128, 1'b0, 1'b1, 0, 1'b0, "R2");
    check_read('h030000, 128, "R4");
    // R4: data phase with zero count -> one zero-length command
    run_req('h000040, 0, 1'b0, 1'b1, 0, 1'b0, "R4");
    // R5: no data phase, count ignored, buffer untouched
    clear_dst();
    run_req('h000010, 50, 1'b0, 1'b0, 0, 1'b0, "R5");
    untouched = 1'b1;
    for (int i = 0; i < 256; i++) if (dst[i] != 8'hEE) untouched = 1'b0;
    check(untouched, "R5", "caller buffer untouched", int'(untouched), 1);
    // R6: controller busy at start, released later
    force_busy = 1'b1;
    fork begin repeat (20) @(negedge clk); force_busy = 1'b0; end join_none
    run_req('h000200, 9, 1'b1, 1'b1, 0, 1'b0, "R6");
    // R7: blocked access
    blk = 1'b1;
    run_req('h000300, 100, 1'b0, 1'b1, 1, 1'b0, "R7");
    blk = 1'b0;
    repeat (10) @(negedge clk);
    // R8: completion never comes
    hang = 1'b1;
    run_req('h000400, 30, 1'b1, 1'b1, 2, 1'b0, "R8");
    hang = 1'b0;
    repeat (10) @(negedge clk);
    // R8: controller stuck busy before first command
    force_busy = 1'b1;
    run_req('h000500, 30, 1'b0, 1'b1, 3, 1'b0, "R8");
    force_busy = 1'b0;
    repeat (5) @(negedge clk);
    // R10: start during a request is ignored
    done_cnt = 0;
    clear_dst();
    run_req('h0001C0, 90, 1'b0, 1'b1, 0, 1'b1, "R10");
    check_read('h0001C0, 90, "R10");
    repeat (20) @(negedge clk);
    check(done_cnt == 1 && !busy, "R10", "one done, engine idle", done_cnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule